// File: doc/BRIEF.md
# Fractional Ratio Cache Clock Generator

This block produces the clock for an external secondary-cache RAM from the core clock. A 3-bit ratio code chooses the divide factor. Three of the factors are half-integers. Every core clock edge, rising and falling, counts as one half-cycle slot. The output is high for the first half of each period, rounded up to whole slots. With an odd slot count, the high and low phases therefore differ by one slot, which is half a core cycle.

A delay-line enable goes high whenever a nonzero ratio is programmed. It tells the deskew loop that a RAM clock exists. The block also handles two power-saving actions while the processor reports a low-power state (nap or sleep). If clock stopping is enabled, the RAM clock halts. If RAM sleep control is enabled, the RAM sleep pin is asserted. Any change to the clock's ratio, and any stop or start, is applied only at a period boundary that falls on a core rising edge. The output is low at such a boundary, so no short pulse can appear.

Top module: `frac_cache_clkgen`

## Requirements
- R1: With ratio code 0 applied, the delay-line enable is low and the RAM clock stays low once the current period ends.
- R2: Codes 1..7 give periods of 2, 3, 7, 4, 5, 6 and 8 half-cycle slots. This is a divide by 1, 1.5, 3.5, 2, 2.5, 3 and 4. The clock is high for the first ceil(period/2) slots of each period and low for the rest. A period starts on a core rising edge.
- R3: The delay-line enable equals (code != 0) for the code sampled at the previous core rising edge.
- R4: When clock stopping is enabled and low power is signalled, the RAM clock halts low at the next boundary. After low power ends, it restarts at a core rising edge at the start of a fresh period.
- R5: The RAM sleep pin equals (sleep control enabled AND low power), as sampled at the previous core rising edge.
- R6: Synchronous active-low reset clears the stored code and all outputs, which leaves the clock stopped and low.
- R7: A new ratio code is applied only at a period boundary. The previous slot at that point was low.
- R8: With clock stopping disabled, the low-power indication has no effect on the RAM clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_code | input | 3 | Divide ratio selection (0 = off) |
| clkstop_en | input | 1 | Enable automatic clock halt in low power |
| ramzz_en | input | 1 | Enable automatic RAM sleep pin |
| low_power | input | 1 | Processor is in nap or sleep |
| ram_clk | output | 1 | Clock to the cache RAMs |
| dline_en | output | 1 | Delay-line (deskew) enable |
| ram_zz | output | 1 | RAM sleep pin |

## Verification
A wrong phase count or a wrong ratio table entry shows at the RAM clock output. It appears within one period of the code being applied, at most 8 half-cycle slots, as a misplaced high or low slot. A wrong boundary decision appears as a period that is stretched or cut short in the slot where the new ratio should begin. A fault on the stop path appears as a clock that keeps running, or a clock that fails to return, within one period of the low-power change. The reference model compares the output in the middle of every half-cycle, so each of these faults shows up in the first slot that differs.

// File: rtl/clkgen_pkg.sv
// Package: shared constants and the ratio-code lookup for the cache clock generator.
// Assumes a 3-bit code; the period is expressed in half-cycle slots of the core clock.
package clkgen_pkg;
    localparam int CODE_W = 3;
    localparam int SLOT_W = 4;

    // Period, in half-cycle slots, selected by a ratio code (0 = clock off).
    function automatic logic [SLOT_W-1:0] period_slots(input logic [CODE_W-1:0] code);
        logic [SLOT_W-1:0] p;
        case (code)
            3'd1:    p = SLOT_W'(2);
            3'd2:    p = SLOT_W'(3);
            3'd3:    p = SLOT_W'(7);
            3'd4:    p = SLOT_W'(4);
            3'd5:    p = SLOT_W'(5);
            3'd6:    p = SLOT_W'(6);
            3'd7:    p = SLOT_W'(8);
            default: p = '0;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/rcg_cfg.sv
// Module: input register stage. It captures the ratio code and the two
// low-power qualifiers on each rising core edge.
// Assumes the inputs are synchronous to the core clock.
module rcg_cfg
    import clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              clkstop_en_i,
    input  logic              ramzz_en_i,
    input  logic              low_power_i,
    output logic [CODE_W-1:0] cfg_o,
    output logic              stop_o,
    output logic              zz_o
);
    // Register the configuration and the qualified low-power requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o  <= '0;
            stop_o <= 1'b0;
            zz_o   <= 1'b0;
        end else begin
            cfg_o  <= code_i;
            stop_o <= clkstop_en_i & low_power_i;
            zz_o   <= ramzz_en_i & low_power_i;
        end
    end
endmodule

// File: rtl/rcg_phase.sv
// Module: half-slot phase engine. It keeps the active ratio, the run state
// and the slot index. Each rising edge it computes the output level for the
// two slots of the coming core cycle.
// Assumes at most 8 slots per period. The ratio, run state and index change
// only at a boundary that falls on a rising edge.
module rcg_phase
    import clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cfg_i,
    input  logic              stop_i,
    output logic              slot_a_o,
    output logic              slot_b_o
);
    logic [CODE_W-1:0] act_q, act_n;
    logic              run_q, run_n;
    logic [SLOT_W-1:0] idx_q, idx_n;
    logic [SLOT_W-1:0] per_cur, per_nxt, hi_nxt, sum, idx_b;
    logic              bnd;

    // Next-state: a boundary loads a new ratio or run state; otherwise the index advances by two slots.
    always_comb begin
        per_cur = period_slots(act_q);
        sum     = idx_q + SLOT_W'(2);
        bnd     = !run_q || (sum == per_cur);
        if (bnd) begin
            act_n = cfg_i;
            run_n = (cfg_i != '0) && !stop_i;
            idx_n = '0;
        end else begin
            act_n = act_q;
            run_n = 1'b1;
            idx_n = (sum >= per_cur) ? sum - per_cur : sum;
        end
        per_nxt = period_slots(act_n);
        hi_nxt  = (per_nxt + SLOT_W'(1)) >> 1;
        idx_b   = idx_n + SLOT_W'(1);
        if (idx_b >= per_nxt) idx_b = idx_b - per_nxt;
    end

    // State and slot-level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= '0;
            run_q    <= 1'b0;
            idx_q    <= '0;
            slot_a_o <= 1'b0;
            slot_b_o <= 1'b0;
        end else begin
            act_q    <= act_n;
            run_q    <= run_n;
            idx_q    <= idx_n;
            slot_a_o <= run_n && (idx_n < hi_nxt);
            slot_b_o <= run_n && (idx_b < hi_nxt);
        end
    end

    AST_SWITCH_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && act_q != $past(act_q)) |-> !$past(slot_b_o)); // R7
    AST_INDEX_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (idx_q < period_slots(act_q))); // R2
    AST_START_NOT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(run_q)) |-> !$past(stop_i)); // R4
endmodule

// File: rtl/rcg_out.sv
// Module: output stage. It carries the second-slot level across to the falling
// edge and selects between the slot levels using the core clock phase.
// Assumes slot levels come from rising-edge registers.
module rcg_out (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_a_i,
    input  logic slot_b_i,
    output logic clk_o
);
    logic slot_b_q;

    // Hold the second-half level from the falling edge onward.
    always_ff @(negedge clk) begin
        if (!rst_n) slot_b_q <= 1'b0;
        else        slot_b_q <= slot_b_i;
    end

    // First half of a core cycle shows slot A, second half shows slot B.
    always_comb clk_o = clk ? slot_a_i : slot_b_q;
endmodule

// File: rtl/frac_cache_clkgen.sv
// Module: top of the fractional-ratio cache RAM clock generator.
// It derives the RAM clock, the delay-line enable and the RAM sleep pin.
// Assumes a single core clock domain with synchronous active-low reset.
module frac_cache_clkgen
    import clkgen_pkg::*;
(
    input  logic              clk_core,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              clkstop_en,
    input  logic              ramzz_en,
    input  logic              low_power,
    output logic              ram_clk,
    output logic              dline_en,
    output logic              ram_zz
);
    logic [CODE_W-1:0] cfg;
    logic              stop, slot_a, slot_b;

    rcg_cfg u_cfg (
        .clk(clk_core), .rst_n(rst_n), .code_i(ratio_code),
        .clkstop_en_i(clkstop_en), .ramzz_en_i(ramzz_en), .low_power_i(low_power),
        .cfg_o(cfg), .stop_o(stop), .zz_o(ram_zz)
    );

    rcg_phase u_phase (
        .clk(clk_core), .rst_n(rst_n), .cfg_i(cfg), .stop_i(stop),
        .slot_a_o(slot_a), .slot_b_o(slot_b)
    );

    rcg_out u_out (
        .clk(clk_core), .rst_n(rst_n), .slot_a_i(slot_a), .slot_b_i(slot_b),
        .clk_o(ram_clk)
    );

    // Delay line runs whenever a nonzero ratio is stored.
    always_comb dline_en = (cfg != '0);

    AST_DLINE_FOLLOWS_CODE: assert property (@(posedge clk_core) disable iff (!rst_n)
        $past(rst_n) |-> (dline_en == ($past(ratio_code) != '0))); // R3
    AST_ZZ_FOLLOWS_LP: assert property (@(posedge clk_core) disable iff (!rst_n)
        $past(rst_n) |-> (ram_zz == ($past(ramzz_en) && $past(low_power)))); // R5
    AST_RESET_CLEARS: assert property (@(posedge clk_core)
        !rst_n |=> (!dline_en && !ram_zz)); // R6
endmodule

// File: tb/sim_frac_cache_clkgen.sv
module sim_frac_cache_clkgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] code = 3'd0;
    logic       cs_en = 1'b0, zz_en = 1'b0, lp = 1'b0;
    logic       ram_clk, dline_en, ram_zz;
    int         n_chk = 0, n_bad = 0;
    string      tag = "R6";

    // Reference model state
    int m_cfg, m_stop, m_zz, m_dl, m_act, m_run, m_idx, m_a, m_b;

    always #2 clk = ~clk;

    frac_cache_clkgen u0 (
        .clk_core(clk), .rst_n(rst_n), .ratio_code(code), .clkstop_en(cs_en),
        .ramzz_en(zz_en), .low_power(lp), .ram_clk(ram_clk),
        .dline_en(dline_en), .ram_zz(ram_zz)
    );

    function automatic int per_of(int c);
        int t[8] = '{0, 2, 3, 7, 4, 5, 6, 8};
        return t[c];
    endfunction

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Advance the model by one rising edge, then compare both half-cycles.
    task automatic cycle();
        int p, hi, s;
        @(posedge clk);
        if (!rst_n) begin
            m_cfg = 0; m_stop = 0; m_zz = 0; m_dl = 0;
            m_act = 0; m_run = 0; m_idx = 0; m_a = 0; m_b = 0;
        end else begin
            p = per_of(m_act);
            if (!m_run || m_idx + 2 == p) begin
                m_act = m_cfg;
                m_run = (m_cfg != 0 && !m_stop) ? 1 : 0;
                m_idx = 0;
            end else begin
                m_idx = (m_idx + 2) % p;
            end
            p  = per_of(m_act);
            hi = (p + 1) / 2;
            s  = (p == 0) ? 0 : (m_idx + 1) % p;
            m_a = (m_run != 0 && m_idx < hi) ? 1 : 0;
            m_b = (m_run != 0 && s < hi) ? 1 : 0;
            m_cfg  = code;
            m_stop = cs_en & lp;
            m_zz   = zz_en & lp;
            m_dl   = (code != 0) ? 1 : 0;
        end
        #1;
        check("ram_clk(first half)", ram_clk, m_a);
        check("dline_en", dline_en, m_dl);
        check("ram_zz", ram_zz, m_zz);
        @(negedge clk);
        #1;
        check("ram_clk(second half)", ram_clk, m_b);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R6: reset state, even with inputs active
        tag = "R6"; code = 3'd5; zz_en = 1'b1; lp = 1'b1;
        run(3);
        code = 3'd0; zz_en = 1'b0; lp = 1'b0; rst_n = 1'b1;
        tag = "R1"; run(6);
        // R2 and R3: every ratio in turn, with R7 covering the transitions between them
        for (int c = 1; c < 8; c++) begin
            code = 3'(c); tag = "R2"; run(2);
            tag = "R7"; run(2);
            tag = "R3"; run(30);
        end
        // R7: quick back-to-back code changes in the middle of periods
        tag = "R7";
        code = 3'd3; run(3); code = 3'd2; run(1); code = 3'd6; run(5);
        code = 3'd1; run(4); code = 3'd3; run(9);
        // R1: code 0 stops the clock and drops the delay line
        tag = "R1"; code = 3'd0; run(20);
        // R4: clock stop on and off
        tag = "R4"; code = 3'd5; cs_en = 1'b1; run(12);
        lp = 1'b1; run(20); lp = 1'b0; run(20);
        code = 3'd3; lp = 1'b1; run(5); lp = 1'b0; run(25);
        // R8: stop disabled, low power ignored by the clock
        tag = "R8"; cs_en = 1'b0; lp = 1'b1; run(30); lp = 1'b0; run(5);
        // R5: sleep pin follows low power when enabled, not otherwise
        tag = "R5"; zz_en = 1'b1; run(4); lp = 1'b1; run(8); lp = 1'b0; run(4);
        zz_en = 1'b0; lp = 1'b1; run(6); lp = 1'b0; zz_en = 1'b1; run(3);
        // R6: reset in the middle of running
        tag = "R6"; code = 3'd7; run(5); rst_n = 1'b0; run(3); rst_n = 1'b1;
        tag = "R2"; run(20);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule